// File: doc/BRIEF.md
# Auto-Incrementing Staging Buffer Port

This block holds the 512-byte staging area that sits between a host register interface and a serial flash sequencer. The host never addresses the storage directly. It programs a control word that picks the transfer direction (fill: the host loads data to be sent; drain: the host unloads received data), optionally turns on auto-increment, and sets a starting word index. It then moves whole 32-bit words through one data window. Each window access can step the word index, so a block transfer is a run of accesses to the same address.

The sequencer side works one byte at a time from its own 9-bit byte pointer. Software loads that pointer, normally with zero, before each request. Each byte the sequencer takes for transmission, or deposits after reception, advances the pointer. Bytes are packed little-endian inside a word, so the host sees the serial stream in natural word order. A transfer whose length is not a multiple of four leaves a final partial word in which only the low-order bytes are meaningful.

Top module: `xsb_stage_buf`

## Requirements
- R1: After reset the control word reads 0x0000_0000 (drain, no auto-increment, index 0) and the sequencer pointer reads 0.
- R2: Host address map: 0 is the control word, 1 is the data window, 2 is the sequencer pointer, and 3 reads 0 and ignores writes. In the control word, bit 31 is the direction (1 = fill, 0 = drain) and bit 30 is auto-increment enable. Bits 7:0 hold the word index, of which only bits 6:0 are stored (bit 7 reads 0). All other bits read 0.
- R3: With auto-increment set, every data-window read or write advances the word index by one after the access, wrapping from 127 to 0. With auto-increment clear, the index holds.
- R4: In fill direction, a data-window write stores the 32-bit word at the current index. In drain direction, the write leaves the storage unchanged, although the index still steps per R3.
- R5: A host read returns its value on host_rdata in the cycle after the read strobe. For the data window this is the word at the index before the access, in either direction, with no side effect other than R3.
- R6: Sequencer byte address b maps to word b/4, bits 8*(b%4)+7 down to 8*(b%4) (little-endian).
- R7: The sequencer pointer is 9 bits. A host write to address 2 loads it from wdata bits 8:0, and a read returns it. Each seq_rd_en or seq_wr_en advances it by one, wrapping from 511 to 0. A host load in the same cycle takes precedence over the advance.
- R8: seq_rd_en returns, on seq_rd_byte in the next cycle, the byte at the pointer value before the advance.
- R9: seq_wr_en stores seq_wr_byte at the byte the pointer addresses before the advance.
- R10: When a host fill write and a sequencer write hit the same word in one cycle, the sequencer byte wins its lane and the host value lands in the other three lanes. A host read in the same cycle as a sequencer write to the same word returns the contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Host register select |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after host_re |
| seq_rd_en | input | 1 | Sequencer takes the next byte for transmission |
| seq_rd_byte | output | 8 | Byte returned the cycle after seq_rd_en |
| seq_wr_en | input | 1 | Sequencer deposits a received byte |
| seq_wr_byte | input | 8 | Received byte |

## Verification
The host data window and the sequencer byte port can touch the same stored word in one clock cycle. The bench provokes this in two ways. First it sets a fixed index with auto-increment clear and aims the sequencer pointer into that word, then raises the host fill write and the sequencer write on the same edge. The merged word is judged lane by lane: one lane must carry the sequencer byte and the other three the host value. Second, a host read is issued together with a sequencer write to the same word. The read must return the old contents, and a following read must show the new byte.

// File: rtl/xsb_pkg.sv
// Package: shared host address codes and control word bit positions for
// the staging buffer. Assumes a 32-bit control word.
package xsb_pkg;
    typedef enum logic [1:0] {
        HA_CTRL = 2'd0,
        HA_DATA = 2'd1,
        HA_PTR  = 2'd2,
        HA_NONE = 2'd3
    } host_addr_e;

    localparam int unsigned DIR_BIT  = 31;
    localparam int unsigned AINC_BIT = 30;
endpackage

// File: rtl/xsb_lane_mem.sv
// One byte lane of the staging storage. Two write ports (host word write,
// sequencer byte write) and two asynchronous read ports. On a same-address
// write the sequencer port takes precedence. Assumes storage needs no reset.
module xsb_lane_mem #(
    parameter int unsigned WORDS = 128,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_byte,
    input  logic          seq_we,
    input  logic [AW-1:0] seq_addr,
    input  logic [7:0]    seq_byte,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem [WORDS];

    // Storage update: host first, sequencer overrides on a shared address.
    always_ff @(posedge clk) begin
        if (host_we) mem[host_addr] <= host_byte;
        if (seq_we)  mem[seq_addr]  <= seq_byte;
    end

    // Asynchronous reads; callers register the result.
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // R10: the sequencer byte is what the addressed entry holds afterwards.
    p_seq_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_we |=> mem[$past(seq_addr)] == $past(seq_byte));

    // R4: an uncontested host write lands in the addressed entry.
    p_host_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !(seq_we && seq_addr == host_addr))
        |=> mem[$past(host_addr)] == $past(host_byte));
endmodule

// File: rtl/xsb_host_ctrl.sv
// Host-side control: holds the direction, auto-increment and word index,
// steps the index on data-window accesses and builds the control readback.
// Assumes at most one of write/read strobe per cycle.
module xsb_host_ctrl #(
    parameter int unsigned WORDS  = 128,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              data_acc,
    input  logic              dir_in,
    input  logic              ainc_in,
    input  logic [AW-1:0]     idx_in,
    output logic              fill_mode,
    output logic [AW-1:0]     idx,
    output logic [WORD_W-1:0] ctrl_word
);
    import xsb_pkg::*;

    logic          ainc;
    logic [AW-1:0] idx_next;

    // Next index with wrap at the last word.
    always_comb begin
        if (idx == AW'(WORDS - 1)) idx_next = '0;
        else                       idx_next = idx + 1'b1;
    end

    // Control register load and index stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_mode <= 1'b0;
            ainc      <= 1'b0;
            idx       <= '0;
        end else if (ctrl_wr) begin
            fill_mode <= dir_in;
            ainc      <= ainc_in;
            idx       <= idx_in;
        end else if (data_acc && ainc) begin
            idx <= idx_next;
        end
    end

    // Control readback image.
    always_comb begin
        ctrl_word           = '0;
        ctrl_word[DIR_BIT]  = fill_mode;
        ctrl_word[AINC_BIT] = ainc;
        ctrl_word[AW-1:0]   = idx;
    end

    // R3: auto-increment steps the index by one with wrap.
    p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && ainc && !ctrl_wr)
        |=> idx == (($past(idx) == AW'(WORDS - 1)) ? '0 : $past(idx) + 1'b1));

    // R3: without auto-increment the index holds across accesses.
    p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ainc && !ctrl_wr) |=> $stable(idx));
endmodule

// File: rtl/xsb_seq_ptr.sv
// Sequencer byte pointer: loaded by the host, advanced by each sequencer
// byte access, wrapping at the buffer end. A load beats an advance.
module xsb_seq_ptr #(
    parameter int unsigned BYTES = 512,
    localparam int unsigned BW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] load_val,
    input  logic          step,
    output logic [BW-1:0] ptr
);
    // Pointer register with load priority and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ptr <= '0;
        else if (load)                      ptr <= load_val;
        else if (step && ptr == BW'(BYTES - 1)) ptr <= '0;
        else if (step)                      ptr <= ptr + 1'b1;
    end

    // R7: a step without load moves the pointer on by one, wrapping.
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load)
        |=> ptr == (($past(ptr) == BW'(BYTES - 1)) ? '0 : $past(ptr) + 1'b1));

    // R7: a host load takes effect even when a step coincides.
    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ptr == $past(load_val));
endmodule

// File: rtl/xsb_stage_buf.sv
// Staging buffer top: byte-lane storage shared by a host word window and a
// sequencer byte port. Host reads and sequencer reads are registered (one
// cycle). Assumes host and sequencer each raise at most one strobe a cycle.
module xsb_stage_buf #(
    parameter int unsigned WORDS  = 128,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned BPW   = WORD_W / 8,
    localparam int unsigned LW    = $clog2(BPW),
    localparam int unsigned AW    = $clog2(WORDS),
    localparam int unsigned BW    = AW + LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              seq_rd_en,
    output logic [7:0]        seq_rd_byte,
    input  logic              seq_wr_en,
    input  logic [7:0]        seq_wr_byte
);
    import xsb_pkg::*;

    logic              fill_mode;
    logic [AW-1:0]     idx;
    logic [WORD_W-1:0] ctrl_word;
    logic [BW-1:0]     ptr;
    logic              ctrl_wr, data_acc, ptr_wr, host_fill_we;
    logic [WORD_W-1:0] host_word;
    logic [7:0]        seq_lane [BPW];

    // Host strobe decode.
    assign ctrl_wr      = host_we && host_addr == HA_CTRL;
    assign ptr_wr       = host_we && host_addr == HA_PTR;
    assign data_acc     = (host_we || host_re) && host_addr == HA_DATA;
    assign host_fill_we = host_we && host_addr == HA_DATA && fill_mode;

    xsb_host_ctrl #(.WORDS(WORDS), .WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .data_acc  (data_acc),
        .dir_in    (host_wdata[DIR_BIT]),
        .ainc_in   (host_wdata[AINC_BIT]),
        .idx_in    (host_wdata[AW-1:0]),
        .fill_mode (fill_mode),
        .idx       (idx),
        .ctrl_word (ctrl_word)
    );

    xsb_seq_ptr #(.BYTES(WORDS * BPW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_wr),
        .load_val (host_wdata[BW-1:0]),
        .step     (seq_rd_en || seq_wr_en),
        .ptr      (ptr)
    );

    // One storage lane per byte of the word; little-endian lane order.
    for (genvar l = 0; l < BPW; l++) begin : g_lane
        xsb_lane_mem #(.WORDS(WORDS)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .host_we   (host_fill_we),
            .host_addr (idx),
            .host_byte (host_wdata[8*l +: 8]),
            .seq_we    (seq_wr_en && ptr[LW-1:0] == LW'(l)),
            .seq_addr  (ptr[BW-1:LW]),
            .seq_byte  (seq_wr_byte),
            .raddr_a   (idx),
            .rdata_a   (host_word[8*l +: 8]),
            .raddr_b   (ptr[BW-1:LW]),
            .rdata_b   (seq_lane[l])
        );
    end

    // Registered host read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) host_rdata <= '0;
        else if (host_re) begin
            case (host_addr)
                HA_CTRL: host_rdata <= ctrl_word;
                HA_DATA: host_rdata <= host_word;
                HA_PTR:  host_rdata <= WORD_W'(ptr);
                default: host_rdata <= '0;
            endcase
        end
    end

    // Registered sequencer byte read, lane picked by the pointer's low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         seq_rd_byte <= '0;
        else if (seq_rd_en) seq_rd_byte <= seq_lane[ptr[LW-1:0]];
    end

    // R2: host strobes are mutually exclusive.
    p_host_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && host_re));

    // R7: sequencer strobes are mutually exclusive.
    p_seq_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_rd_en && seq_wr_en));

    // R5: a control read returns the control image seen at the strobe.
    p_ctrl_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && host_addr == HA_CTRL) |=> host_rdata == $past(ctrl_word));
endmodule

// File: tb/xsb_stage_buf_tb.sv
module xsb_stage_buf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = '0;
    logic        host_we = 1'b0, host_re = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        seq_rd_en = 1'b0, seq_wr_en = 1'b0;
    logic [7:0]  seq_rd_byte, seq_wr_byte = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xsb_stage_buf u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
        .host_re(host_re), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .seq_rd_en(seq_rd_en), .seq_rd_byte(seq_rd_byte),
        .seq_wr_en(seq_wr_en), .seq_wr_byte(seq_wr_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); host_addr = a; host_re = 1'b1;
        @(negedge clk); host_re = 1'b0; d = host_rdata;
    endtask

    task automatic srd(output logic [7:0] b);
        @(negedge clk); seq_rd_en = 1'b1;
        @(negedge clk); seq_rd_en = 1'b0; b = seq_rd_byte;
    endtask

    task automatic swr(input logic [7:0] b);
        @(negedge clk); seq_wr_en = 1'b1; seq_wr_byte = b;
        @(negedge clk); seq_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        hrd(2'd0, d); chk("R1 ctrl after reset", d, 32'h0);
        hrd(2'd2, d); chk("R1 pointer after reset", d, 32'h0);
    endtask

    task automatic t_ctrl;
        logic [31:0] d;
        hwr(2'd0, 32'hC000_00FF); hrd(2'd0, d); chk("R2 ctrl fields", d, 32'hC000_007F);
        hwr(2'd0, 32'h3FFF_FF05); hrd(2'd0, d); chk("R2 ctrl unused bits", d, 32'h0000_0005);
        hwr(2'd3, 32'hFFFF_FFFF); hrd(2'd3, d); chk("R2 address 3", d, 32'h0);
    endtask

    task automatic t_fill_drain;
        logic [31:0] d;
        logic [31:0] w [4] = '{32'h3322_1100, 32'h7766_5544, 32'hBBAA_9988, 32'hFFEE_DDCC};
        hwr(2'd0, 32'hC000_0000);
        for (int i = 0; i < 4; i++) hwr(2'd1, w[i]);
        hrd(2'd0, d); chk("R3 index after 4 writes", d, 32'hC000_0004);
        hwr(2'd0, 32'h4000_0000);
        for (int i = 0; i < 4; i++) begin
            hrd(2'd1, d); chk("R5 drain read word", d, w[i]);
        end
        hrd(2'd0, d); chk("R3 index after 4 reads", d, 32'h4000_0004);
        hwr(2'd0, 32'hC000_0002); hrd(2'd1, d); chk("R5 read in fill mode", d, w[2]);
        hrd(2'd0, d); chk("R3 read steps index", d, 32'hC000_0003);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        hwr(2'd0, 32'hC000_007F); hwr(2'd1, 32'h1234_5678);
        hrd(2'd0, d); chk("R3 wrap 127 to 0", d, 32'hC000_0000);
        hwr(2'd0, 32'h4000_007F); hrd(2'd1, d); chk("R4 word 127 stored", d, 32'h1234_5678);
    endtask

    task automatic t_no_ainc;
        logic [31:0] d;
        hwr(2'd0, 32'h8000_0005); hwr(2'd1, 32'h0A0A_0A0A); hwr(2'd1, 32'h5050_5050);
        hrd(2'd0, d); chk("R3 index holds", d, 32'h8000_0005);
        hrd(2'd1, d); chk("R4 last write kept", d, 32'h5050_5050);
    endtask

    task automatic t_drain_ignore;
        logic [31:0] d;
        hwr(2'd0, 32'h4000_0000); hwr(2'd1, 32'hDEAD_BEEF);
        hrd(2'd0, d); chk("R4 drain write steps index", d, 32'h4000_0001);
        hwr(2'd0, 32'h0000_0000); hrd(2'd1, d); chk("R4 drain write ignored", d, 32'h3322_1100);
    endtask

    task automatic t_seq_read;
        logic [7:0] b;
        logic [31:0] d;
        hwr(2'd2, 32'h0);
        for (int i = 0; i < 8; i++) begin
            srd(b); chk("R8 R6 seq byte order", {24'h0, b}, 32'(i * 8'h11));
        end
        hrd(2'd2, d); chk("R7 pointer after reads", d, 32'd8);
    endtask

    task automatic t_seq_write;
        logic [31:0] d;
        hwr(2'd2, 32'd16);
        swr(8'h11); swr(8'h22); swr(8'h33); swr(8'h44); swr(8'h55);
        hwr(2'd0, 32'h4000_0004);
        hrd(2'd1, d); chk("R9 R6 packed word", d, 32'h4433_2211);
        hrd(2'd1, d); chk("R9 partial word low byte", d & 32'hFF, 32'h55);
    endtask

    task automatic t_ptr_wrap;
        logic [31:0] d;
        hwr(2'd2, 32'd511); swr(8'h99);
        hrd(2'd2, d); chk("R7 pointer wrap", d, 32'd0);
        hwr(2'd0, 32'h0000_007F); hrd(2'd1, d); chk("R6 byte 511 lane 3", d, 32'h9934_5678);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        hwr(2'd0, 32'h8000_0002); hwr(2'd2, 32'd9);
        @(negedge clk);
        host_addr = 2'd1; host_wdata = 32'hAABB_CCDD; host_we = 1'b1;
        seq_wr_en = 1'b1; seq_wr_byte = 8'h5A;
        @(negedge clk); host_we = 1'b0; seq_wr_en = 1'b0;
        hrd(2'd1, d); chk("R10 same-cycle write merge", d, 32'hAABB_5ADD);
        hwr(2'd2, 32'd8);
        @(negedge clk);
        host_addr = 2'd1; host_re = 1'b1; seq_wr_en = 1'b1; seq_wr_byte = 8'h11;
        @(negedge clk); host_re = 1'b0; seq_wr_en = 1'b0; d = host_rdata;
        chk("R10 same-cycle read sees old", d, 32'hAABB_5ADD);
        hrd(2'd1, d); chk("R10 later read sees new", d, 32'hAABB_5A11);
    endtask

    task automatic t_load_wins;
        logic [31:0] d;
        @(negedge clk);
        host_addr = 2'd2; host_wdata = 32'd100; host_we = 1'b1; seq_rd_en = 1'b1;
        @(negedge clk); host_we = 1'b0; seq_rd_en = 1'b0;
        hrd(2'd2, d); chk("R7 load beats step", d, 32'd100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_fill_drain();
        t_wrap();
        t_no_ainc();
        t_drain_ignore();
        t_seq_read();
        t_seq_write();
        t_ptr_wrap();
        t_collide();
        t_load_wins();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule